// File: doc/BRIEF.md
# Ethernet Controller Host Register Port

This block is the register face of a descriptor-ring Ethernet controller. The host sees only two 16-bit locations. Offset 1 holds a small pointer. Offset 0 reaches whichever of four control/status registers the pointer selects. Register 0 is the command and status word. It carries sticky event flags that the host clears by writing ones, the run flags, an error summary and an interrupt summary.

Registers 1 and 2 together give the byte address of an initialization block in memory. When the host sets the init command, the block fetches six 32-bit words over a request/acknowledge DMA port. It decodes them into the operating mode, the 48-bit station address, the 64-bit multicast filter, and the base address and entry count of the receive and transmit rings. The ring engines outside this block use those outputs, feed their events into the flag inputs, and reset their ring positions on a one-cycle pulse.

While the fetch is running, every host write is ignored and the busy output is high.

Top module: `nic_csr_port`

## Requirements
- R1: After reset, register 0 reads 0x0004 (only the stop bit, bit 2, set), the pointer reads 0, and busy and irq are low.
- R2: A write at offset 1 (reg_sel=1) stores the low 2 bits of the data as the pointer; a read at offset 1 returns the pointer with all upper bits 0; offset 0 reads and writes the register that the pointer selects.
- R3: Register 1 keeps data bits 15:1 (bit 0 reads 0), register 2 keeps bits 7:0 and register 3 keeps bits 2:0; all other bits read 0.
- R4: evt_flags bits 5..0 set register-0 bits 14 (babble), 13 (collision error), 12 (missed frame), 11 (memory error), 10 (receive interrupt) and 9 (transmit interrupt). Bit 15 reads as the OR of bits 14..11. Writing a 1 to any of bits 14..8 clears that bit, and writing 0 leaves it unchanged. An event in the same cycle as a clearing write keeps the bit set.
- R5: Bit 7 of register 0 and the irq output are high exactly when any of bits 14, 12, 11, 10, 9 or 8 (init done) is set; bit 13 alone raises neither.
- R6: A register-0 write with bit 2 set clears init-done (8), receiver-on (5), transmitter-on (4), start (1) and init (0), sets stop, zeroes register 3, and ignores bits 0 and 1 of that same write.
- R7: A register-0 write with bit 0 set (bit 2 clear) starts a fetch. The fetch reads six words at byte addresses {reg2[7:0], reg1[15:1], 0} + 4*i, i = 0..5, in order. dma_req stays high with a stable dma_addr until dma_ack, and busy is high from the write until register 0 shows completion.
- R8: Word i holds field 2i in bits 31:16 and field 2i+1 in bits 15:0. Field 0 is mode_word. Fields 3,2,1 form station_addr, most significant first. Fields 7..4 form mcast_filter, most significant first.
- R9: The receive ring base is {field9[7:0], field8[15:3], 000} and its length is 2 to the power field9[15:13]. The transmit ring uses fields 11 and 10 the same way.
- R10: When the fetch completes, stop is cleared; init-done, init, receiver-on and transmitter-on are set; and ring_pos_clr pulses for one cycle.
- R11: A register-0 write with bit 1 set (bit 2 clear) clears stop and sets the start bit. It clears receiver-on if mode bit 0 is set and transmitter-on if mode bit 1 is set. Given together with init, this takes effect at fetch completion, using the newly fetched mode.
- R12: While busy is high, every host write at either offset is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Host location: 0 = selected register, 1 = pointer |
| reg_wr | input | 1 | Host write strobe |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data for the current reg_sel |
| busy | output | 1 | Init fetch in progress; writes are ignored |
| irq | output | 1 | Interrupt summary |
| evt_flags | input | 6 | One-cycle event pulses from the ring engines |
| dma_req | output | 1 | DMA read request |
| dma_addr | output | 24 | DMA byte address |
| dma_ack | input | 1 | DMA acknowledge; dma_rdata valid |
| dma_rdata | input | 32 | DMA read data |
| mode_word | output | 16 | Decoded mode field |
| station_addr | output | 48 | Decoded station address |
| mcast_filter | output | 64 | Decoded multicast filter |
| rx_ring_base | output | 24 | Receive ring base byte address |
| rx_ring_len | output | 8 | Receive ring entry count |
| tx_ring_base | output | 24 | Transmit ring base byte address |
| tx_ring_len | output | 8 | Transmit ring entry count |
| ring_pos_clr | output | 1 | One-cycle pulse that resets both ring positions |

## Verification
The assertions assume the DMA side answers each request with a single-cycle acknowledge. They also assume the host drives reg_wr and reg_wdata as clean values at the clock edge. They do not assume the host avoids writing while busy, because the hold-off is itself checked. The stimulus meets these assumptions: a responder gives one acknowledge every other cycle while dma_req is high, and host writes and event pulses change only on the falling edge. The stimulus also checks each fetched address against the programmed base, so a word read out of order is reported.

// File: rtl/nic_csr_pkg.sv
`timescale 1ns/1ps
// Shared constants for the host register port: widths, the field count of
// the initialization block, and the bit positions of register 0.
package nic_csr_pkg;
    localparam int REG_W      = 16;
    localparam int BUS_ADDR_W = 24;
    localparam int DMA_W      = 32;
    localparam int INIT_WORDS = 6;
    localparam int LEN_W      = 8;
    localparam int EVT_W      = 6;
    localparam int FLAG_W     = EVT_W + 1;   // event flags plus init-done
    localparam int WIDX_W     = $clog2(INIT_WORDS);

    // Register 0 bit positions (software decodes these)
    localparam int B_INIT = 0;
    localparam int B_STRT = 1;
    localparam int B_STOP = 2;
    localparam int B_TXON = 4;
    localparam int B_RXON = 5;
    localparam int B_INTR = 7;
    localparam int B_FLAG_LO = 8;            // init-done, first W1C flag
    localparam int B_ERR  = 15;

    // Mode bits that gate the run flags on start
    localparam int M_NO_RX = 0;
    localparam int M_NO_TX = 1;

    typedef logic [INIT_WORDS-1:0][DMA_W-1:0] init_words_t;
endpackage

// File: rtl/nic_init_fetch.sv
`timescale 1ns/1ps
// Reads the initialization block word by word over a request/acknowledge
// DMA port. Assumes dma_ack is a single-cycle response to a held request.
// Each word is stored in its own register as it arrives; done pulses one
// cycle after the last acknowledge.
module nic_init_fetch
    import nic_csr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [BUS_ADDR_W-1:0] base,
    output logic                  dma_req,
    output logic [BUS_ADDR_W-1:0] dma_addr,
    input  logic                  dma_ack,
    input  logic [DMA_W-1:0]      dma_rdata,
    output init_words_t           words,
    output logic                  active,
    output logic                  done
);
    logic [WIDX_W-1:0]     idx_q;
    logic [BUS_ADDR_W-1:0] base_q;
    logic                  take;

    assign take     = active && dma_ack;
    assign dma_req  = active;
    assign dma_addr = base_q + BUS_ADDR_W'({idx_q, 2'b00});

    // Sequencer: latch base on start, step the word index on each acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx_q  <= '0;
            base_q <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !active) begin
                active <= 1'b1;
                idx_q  <= '0;
                base_q <= base;
            end else if (take) begin
                if (idx_q == WIDX_W'(INIT_WORDS - 1)) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // One storage register per block word, loaded when its index is acknowledged.
    for (genvar g = 0; g < INIT_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[g] <= '0;
            else if (take && idx_q == WIDX_W'(g))
                words[g] <= dma_rdata;
        end
    end
endmodule

// File: rtl/nic_init_decode.sv
`timescale 1ns/1ps
// Pure decode of the stored initialization words into mode, station address,
// multicast filter and ring parameters. Word i carries field 2i in its upper
// half. Assumes nothing about timing; outputs follow the word registers.
module nic_init_decode
    import nic_csr_pkg::*;
(
    input  init_words_t           words,
    output logic [REG_W-1:0]      mode_word,
    output logic [47:0]           station_addr,
    output logic [63:0]           mcast_filter,
    output logic [BUS_ADDR_W-1:0] rx_ring_base,
    output logic [LEN_W-1:0]      rx_ring_len,
    output logic [BUS_ADDR_W-1:0] tx_ring_base,
    output logic [LEN_W-1:0]      tx_ring_len
);
    function automatic logic [REG_W-1:0] field(input init_words_t w, input int k);
        return (k % 2 == 1) ? w[k/2][REG_W-1:0] : w[k/2][DMA_W-1:REG_W];
    endfunction

    logic [BUS_ADDR_W-1:0] base_a [2];
    logic [LEN_W-1:0]      len_a  [2];

    assign mode_word    = field(words, 0);
    assign station_addr = {field(words, 3), field(words, 2), field(words, 1)};
    assign mcast_filter = {field(words, 7), field(words, 6), field(words, 5), field(words, 4)};

    // Ring 0 is receive (fields 8,9), ring 1 is transmit (fields 10,11).
    for (genvar g = 0; g < 2; g++) begin : g_ring
        logic [REG_W-1:0] lo_f, hi_f;
        assign lo_f      = field(words, 8 + 2*g);
        assign hi_f      = field(words, 9 + 2*g);
        assign base_a[g] = {hi_f[7:0], lo_f[15:3], 3'b000};
        assign len_a[g]  = LEN_W'(1) << hi_f[15:13];
    end

    assign rx_ring_base = base_a[0];
    assign rx_ring_len  = len_a[0];
    assign tx_ring_base = base_a[1];
    assign tx_ring_len  = len_a[1];
endmodule

// File: rtl/nic_csr_port.sv
`timescale 1ns/1ps
// Host register port of the Ethernet controller. A 2-bit pointer selects one
// of four registers; register 0 holds W1C event flags, run flags and the
// stop/init/start commands. Init fetches the block through nic_init_fetch.
// Assumes the host drives reg_* synchronously to clk.
module nic_csr_port
    import nic_csr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_sel,
    input  logic                  reg_wr,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    output logic                  busy,
    output logic                  irq,
    input  logic [EVT_W-1:0]      evt_flags,
    output logic                  dma_req,
    output logic [BUS_ADDR_W-1:0] dma_addr,
    input  logic                  dma_ack,
    input  logic [DMA_W-1:0]      dma_rdata,
    output logic [REG_W-1:0]      mode_word,
    output logic [47:0]           station_addr,
    output logic [63:0]           mcast_filter,
    output logic [BUS_ADDR_W-1:0] rx_ring_base,
    output logic [LEN_W-1:0]      rx_ring_len,
    output logic [BUS_ADDR_W-1:0] tx_ring_base,
    output logic [LEN_W-1:0]      tx_ring_len,
    output logic                  ring_pos_clr
);
    logic [1:0]        rap_q;
    logic [REG_W-1:1]  csr1_q;
    logic [7:0]        csr2_q;
    logic [2:0]        csr3_q;
    logic [FLAG_W-1:0] flag_q;      // register 0 bits 14..8
    logic              stop_q, strt_q, init_q, rxon_q, txon_q, strt_pend_q;
    logic              fetch_active, fetch_done;
    logic              wr_ok, csr0_wr, cmd_stop, cmd_init, cmd_strt;
    logic              err_sum, intr_sum;
    logic [FLAG_W-1:0] flag_set, flag_clr;
    logic [REG_W-1:0]  csr0_val;
    init_words_t       words;

    assign busy     = fetch_active || fetch_done;
    assign wr_ok    = reg_wr && !busy;
    assign csr0_wr  = wr_ok && !reg_sel && rap_q == 2'd0;
    assign cmd_stop = csr0_wr && reg_wdata[B_STOP];
    assign cmd_init = csr0_wr && !reg_wdata[B_STOP] && reg_wdata[B_INIT];
    assign cmd_strt = csr0_wr && !reg_wdata[B_STOP] && reg_wdata[B_STRT];

    nic_init_fetch u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cmd_init),
        .base      ({csr2_q, csr1_q, 1'b0}),
        .dma_req   (dma_req),
        .dma_addr  (dma_addr),
        .dma_ack   (dma_ack),
        .dma_rdata (dma_rdata),
        .words     (words),
        .active    (fetch_active),
        .done      (fetch_done)
    );

    nic_init_decode u_decode (
        .words        (words),
        .mode_word    (mode_word),
        .station_addr (station_addr),
        .mcast_filter (mcast_filter),
        .rx_ring_base (rx_ring_base),
        .rx_ring_len  (rx_ring_len),
        .tx_ring_base (tx_ring_base),
        .tx_ring_len  (tx_ring_len)
    );

    assign ring_pos_clr = fetch_done;

    // Pointer and address/bus registers: masked stores, stop clears register 3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rap_q  <= '0;
            csr1_q <= '0;
            csr2_q <= '0;
            csr3_q <= '0;
        end else if (wr_ok) begin
            if (reg_sel)
                rap_q <= reg_wdata[1:0];
            else if (rap_q == 2'd1)
                csr1_q <= reg_wdata[REG_W-1:1];
            else if (rap_q == 2'd2)
                csr2_q <= reg_wdata[7:0];
            else if (rap_q == 2'd3)
                csr3_q <= reg_wdata[2:0];
            if (cmd_stop)
                csr3_q <= '0;
        end
    end

    // Sticky flags: events and init completion set, host ones and stop clear; set wins.
    assign flag_set = {evt_flags, fetch_done};
    assign flag_clr = (csr0_wr ? reg_wdata[B_ERR-1:B_FLAG_LO] : '0)
                    | {{(FLAG_W-1){1'b0}}, cmd_stop};
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~flag_clr) | flag_set;
    end

    // Run flags and commands: stop dominates, completion applies deferred start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= 1'b1;
            strt_q <= 1'b0;
            init_q <= 1'b0;
            rxon_q <= 1'b0;
            txon_q <= 1'b0;
            strt_pend_q <= 1'b0;
        end else if (cmd_stop) begin
            stop_q <= 1'b1;
            strt_q <= 1'b0;
            init_q <= 1'b0;
            rxon_q <= 1'b0;
            txon_q <= 1'b0;
            strt_pend_q <= 1'b0;
        end else if (fetch_done) begin
            stop_q <= 1'b0;
            init_q <= 1'b1;
            rxon_q <= !(strt_pend_q && mode_word[M_NO_RX]);
            txon_q <= !(strt_pend_q && mode_word[M_NO_TX]);
            if (strt_pend_q) strt_q <= 1'b1;
            strt_pend_q <= 1'b0;
        end else if (cmd_init) begin
            strt_pend_q <= reg_wdata[B_STRT];
        end else if (cmd_strt) begin
            stop_q <= 1'b0;
            strt_q <= 1'b1;
            if (mode_word[M_NO_RX]) rxon_q <= 1'b0;
            if (mode_word[M_NO_TX]) txon_q <= 1'b0;
        end
    end

    // Summaries: error over the four error flags, interrupt over all but collision.
    assign err_sum  = |flag_q[FLAG_W-1:FLAG_W-4];
    assign intr_sum = flag_q[6] | flag_q[4] | flag_q[3] | flag_q[2] | flag_q[1] | flag_q[0];
    assign irq      = intr_sum;

    // Register 0 image as the host sees it.
    always_comb begin
        csr0_val         = '0;
        csr0_val[B_ERR]  = err_sum;
        csr0_val[B_ERR-1:B_FLAG_LO] = flag_q;
        csr0_val[B_INTR] = intr_sum;
        csr0_val[B_RXON] = rxon_q;
        csr0_val[B_TXON] = txon_q;
        csr0_val[B_STOP] = stop_q;
        csr0_val[B_STRT] = strt_q;
        csr0_val[B_INIT] = init_q;
    end

    // Read mux over pointer and the selected register.
    always_comb begin
        if (reg_sel) begin
            reg_rdata = {{(REG_W-2){1'b0}}, rap_q};
        end else begin
            case (rap_q)
                2'd0:    reg_rdata = csr0_val;
                2'd1:    reg_rdata = {csr1_q, 1'b0};
                2'd2:    reg_rdata = {8'h00, csr2_q};
                default: reg_rdata = {13'h0000, csr3_q};
            endcase
        end
    end
endmodule

// File: rtl/nic_csr_port_chk.sv
`timescale 1ns/1ps
// Property checker for nic_csr_port, bound into every instance.
// Assumes single-cycle dma_ack and synchronous host strobes.
module nic_csr_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_sel,
    input logic        reg_wr,
    input logic [15:0] reg_wdata,
    input logic        busy,
    input logic        dma_req,
    input logic        dma_ack,
    input logic [23:0] dma_addr,
    input logic [1:0]  rap_q,
    input logic [2:0]  csr3_q,
    input logic        stop_q,
    input logic        rxon_q,
    input logic        txon_q,
    input logic        idon_q,
    input logic        fetch_done
);
    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && !dma_ack |=> dma_req && $stable(dma_addr));

    assert_req_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> busy);

    assert_done_runs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_done |=> !stop_q && idon_q);

    assert_stop_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && !busy && !reg_sel && rap_q == 2'd0 && reg_wdata[2]
        |=> stop_q && csr3_q == 3'd0 && !rxon_q && !txon_q);

    assert_stopped_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_q |-> !rxon_q && !txon_q && !idon_q);

    assert_busy_holdoff_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy && reg_wr |=> $stable(rap_q) && $stable(csr3_q));
endmodule

bind nic_csr_port nic_csr_port_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_sel    (reg_sel),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .busy       (busy),
    .dma_req    (dma_req),
    .dma_ack    (dma_ack),
    .dma_addr   (dma_addr),
    .rap_q      (rap_q),
    .csr3_q     (csr3_q),
    .stop_q     (stop_q),
    .rxon_q     (rxon_q),
    .txon_q     (txon_q),
    .idon_q     (flag_q[0]),
    .fetch_done (fetch_done)
);

// File: tb/nic_csr_port_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected values, a monitor pops and
// compares them shortly after each falling edge.
module nic_csr_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        busy, irq;
    logic [5:0]  evt_flags = '0;
    logic        dma_req;
    logic [23:0] dma_addr;
    logic        dma_ack = 1'b0;
    logic [31:0] dma_rdata = '0;
    logic [15:0] mode_word;
    logic [47:0] station_addr;
    logic [63:0] mcast_filter;
    logic [23:0] rx_ring_base, tx_ring_base;
    logic [7:0]  rx_ring_len, tx_ring_len;
    logic        ring_pos_clr;

    always #2.5 clk = ~clk;

    nic_csr_port dut_i (.*);

    typedef enum int {K_REG, K_BUSY, K_IRQ, K_MODE, K_PHYS, K_LAF,
                      K_RXB, K_RXL, K_TXB, K_TXL, K_CLR} kind_t;
    typedef struct {
        kind_t       kind;
        logic [63:0] exp;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    int          n_chk = 0;
    int          n_fail = 0;
    int          clr_cnt = 0;
    int          resp_cnt = 0;
    logic [23:0] exp_base = '0;
    logic [15:0] fld [12];

    function automatic logic [63:0] probe(kind_t k);
        case (k)
            K_REG:  return 64'(reg_rdata);
            K_BUSY: return 64'(busy);
            K_IRQ:  return 64'(irq);
            K_MODE: return 64'(mode_word);
            K_PHYS: return 64'(station_addr);
            K_LAF:  return mcast_filter;
            K_RXB:  return 64'(rx_ring_base);
            K_RXL:  return 64'(rx_ring_len);
            K_TXB:  return 64'(tx_ring_base);
            K_TXL:  return 64'(tx_ring_len);
            default: return 64'(clr_cnt);
        endcase
    endfunction

    // Monitor: compare every queued expectation just after the falling edge.
    always @(negedge clk) begin
        #1;
        while (sb_q.size() > 0) begin
            item_t it;
            logic [63:0] act;
            it  = sb_q.pop_front();
            act = probe(it.kind);
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    // DMA responder: one acknowledge every other cycle, address checked against the base.
    always @(negedge clk) begin
        if (dma_req && !dma_ack) begin
            logic [23:0] want;
            want = exp_base + 24'(resp_cnt * 4);
            n_chk++;
            if (dma_addr !== want) begin
                n_fail++;
                $display("FAIL R7: actual %h expected %h", dma_addr, want);
            end
            dma_rdata = (resp_cnt < 6) ? {fld[2*resp_cnt], fld[2*resp_cnt+1]} : 32'hDEAD_BEEF;
            dma_ack   = 1'b1;
            resp_cnt++;
        end else begin
            dma_ack = 1'b0;
        end
    end

    // Count ring-position clear pulses away from the clock edge.
    always @(negedge clk) if (rst_n && ring_pos_clr) clr_cnt++;

    task automatic expect_val(kind_t k, logic [63:0] e, string tag);
        @(negedge clk);
        sb_q.push_back('{k, e, tag});
    endtask

    task automatic expect_reg(logic sel, logic [15:0] e, string tag);
        @(negedge clk);
        reg_sel = sel;
        sb_q.push_back('{K_REG, 64'(e), tag});
    endtask

    task automatic wr(logic sel, logic [15:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse_evt(logic [5:0] v);
        @(negedge clk);
        evt_flags = v;
        @(negedge clk);
        evt_flags = '0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        fld = '{16'h0000, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h5555,
                16'h6666, 16'h7777, 16'hABCF, 16'h6012, 16'h0007, 16'hE0FF};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        expect_reg(0, 16'h0004, "R1 csr0");
        expect_reg(1, 16'h0000, "R1 pointer");
        expect_val(K_BUSY, 0, "R1 busy");
        expect_val(K_IRQ, 0, "R1 irq");

        // R2 / R3: pointer masking and register widths
        wr(1, 16'hFFFE);
        expect_reg(1, 16'h0002, "R2 pointer low bits");
        wr(0, 16'hFFFF);
        expect_reg(0, 16'h00FF, "R3 reg2 width");
        wr(1, 16'h0001);
        wr(0, 16'hFFFF);
        expect_reg(0, 16'hFFFE, "R3 reg1 bit0");
        wr(1, 16'h0003);
        wr(0, 16'hFFFF);
        expect_reg(0, 16'h0007, "R3 reg3 width");
        expect_reg(1, 16'h0003, "R2 pointer readback");

        // R7: init block at 0x561234 (bit 0 of reg1 dropped)
        wr(1, 16'h0001); wr(0, 16'h1235);
        wr(1, 16'h0002); wr(0, 16'h0056);
        wr(1, 16'h0000);
        exp_base = 24'h561234; resp_cnt = 0;
        wr(0, 16'h0001);
        expect_val(K_BUSY, 1, "R7 busy during fetch");
        wr(1, 16'h0002);                         // R12: ignored while busy
        wait_idle();
        expect_reg(1, 16'h0000, "R12 pointer unchanged");
        expect_reg(0, 16'h01B1, "R10 csr0 after init");
        expect_val(K_IRQ, 1, "R5 irq on init done");
        expect_val(K_CLR, 1, "R10 ring clear pulse");
        expect_val(K_MODE, 64'h0000, "R8 mode");
        expect_val(K_PHYS, 64'h333322221111, "R8 station");
        expect_val(K_LAF, 64'h7777666655554444, "R8 filter");
        expect_val(K_RXB, 64'h12ABC8, "R9 rx base");
        expect_val(K_RXL, 8, "R9 rx len");
        expect_val(K_TXB, 64'hFF0000, "R9 tx base");
        expect_val(K_TXL, 128, "R9 tx len");

        // R4 / R5: W1C and summaries
        wr(0, 16'h0100);
        expect_reg(0, 16'h0031, "R4 clear init-done");
        expect_val(K_IRQ, 0, "R5 irq low");
        pulse_evt(6'b000010);
        expect_reg(0, 16'h04B1, "R4 receive flag");
        expect_val(K_IRQ, 1, "R5 irq on receive flag");
        wr(0, 16'h0400);
        pulse_evt(6'b010000);
        expect_reg(0, 16'hA031, "R4 collision sets err");
        expect_val(K_IRQ, 0, "R5 collision no irq");
        wr(0, 16'h0000);
        expect_reg(0, 16'hA031, "R4 zero write no effect");
        wr(0, 16'h2000);
        expect_reg(0, 16'h0031, "R4 collision cleared");
        @(negedge clk);
        evt_flags = 6'b001000; reg_sel = 0; reg_wdata = 16'h1000; reg_wr = 1'b1;
        @(negedge clk);
        evt_flags = '0; reg_wr = 1'b0;
        expect_reg(0, 16'h90B1, "R4 set wins over clear");
        wr(0, 16'h1000);

        // R6: stop with init and start in same write
        wr(1, 16'h0003); wr(0, 16'h0005);
        wr(1, 16'h0000);
        wr(0, 16'h0007);
        expect_reg(0, 16'h0004, "R6 stop state");
        expect_val(K_BUSY, 0, "R6 init ignored with stop");
        wr(1, 16'h0003);
        expect_reg(0, 16'h0000, "R6 reg3 zeroed");
        wr(1, 16'h0000);

        // R11: start alone
        wr(0, 16'h0002);
        expect_reg(0, 16'h0002, "R11 start clears stop");

        // R11: init plus start with both disables
        fld[0] = 16'h0003; resp_cnt = 0;
        wr(0, 16'h0003);
        wait_idle();
        expect_reg(0, 16'h0183, "R11 deferred start both off");
        expect_val(K_MODE, 64'h0003, "R8 new mode");
        expect_val(K_CLR, 2, "R10 second clear pulse");

        // R11: receive disable only
        fld[0] = 16'h0001; resp_cnt = 0;
        wr(0, 16'h0003);
        wait_idle();
        expect_reg(0, 16'h0193, "R11 receive off only");

        repeat (3) @(negedge clk);
        summary();
    end
endmodule